// File: doc/BRIEF.md
# Tagged Calibration Shadow Loader

This block keeps a set of five 12-bit calibration and configuration registers in step with a small non-volatile word array. On each refresh tick it walks the array from the lowest address to the highest, one read per cycle. Each stored 16-bit word carries a 4-bit destination tag in bits 15:12 and a 12-bit payload in bits 11:0. The tag decides which shadow register receives the payload. The word's address has no say in the destination, so a word whose tag is wrong or zero changes nothing.

Refresh runs only while the write-enable input is high and the communication-active input is low. The permit output for array erase and write follows write-enable. A pass that loses its enable partway through stops at once. Words already committed stay, and no later word is applied. The tick source is external and is meant to pulse about every 2.5 ms.

Top module: `calib_shadow_loader`

## Requirements
- R1: While reset is asserted and after it is released, all five shadow registers read zero, `busy_o` is low and `mem_rd_o` is low until the first pass starts.
- R2: A committed word with tag 4'b1000 loads `cfg_o`, 4'b1001 loads `ofs_o`, 4'b1010 loads `ofs_tc_o`, 4'b1011 loads `fso_o` and 4'b1100 loads `fso_tc_o`. In each case the register receives bits 11:0 of the word.
- R3: A word whose tag is 4'b0000, or any code not listed in R2, updates no register.
- R4: The destination comes only from the tag. A word at address 0 tagged 4'b1011 loads `fso_o`, and a word with a zero tag at address 3 leaves `fso_o` alone.
- R5: A tick seen while idle with refresh enabled starts a pass. `busy_o` goes high on the next cycle and stays high for exactly 8 cycles, while `mem_addr_o` steps 0,1,...,7, one address per cycle. The array answers one cycle after each read.
- R6: While write-enable is low, `prog_permit_o` is low and ticks start no pass. While write-enable is high, `prog_permit_o` is high.
- R7: While communication-active is high, ticks start no pass, whatever the level of write-enable.
- R8: If refresh becomes disabled during a pass, `busy_o` drops on the next cycle and no further word is committed. Outside of committed words, the registers hold their values.
- R9: If two words in one pass carry the same tag, the word at the higher address decides the final value.
- R10: A tick arriving during a pass neither restarts nor extends that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Refresh pacing strobe, one cycle wide |
| wr_en_i | input | 1 | Write-enable level; gates refresh and the array permit |
| comm_active_i | input | 1 | High while a serial session is in progress; blocks refresh |
| mem_rd_o | output | 1 | Read strobe to the word array |
| mem_addr_o | output | 3 | Word address being read |
| mem_data_i | input | 16 | Word returned one cycle after the read |
| prog_permit_o | output | 1 | Erase/write permit for the array |
| busy_o | output | 1 | High while a pass is in progress |
| cfg_o | output | 12 | Configuration shadow register |
| ofs_o | output | 12 | Offset shadow register |
| ofs_tc_o | output | 12 | Offset temperature-coefficient shadow register |
| fso_o | output | 12 | Full-scale output shadow register |
| fso_tc_o | output | 12 | Full-scale temperature-coefficient shadow register |

## Verification
The hardest case to reach from the ports is a pass that is cut off partway. The enable has to fall after some words have already been committed and while others are still in flight. The bench waits for `mem_addr_o` to show address 2, then drops write-enable half a cycle later. At that point the first word has landed and the second word is on the data bus. The bench then expects only the configuration register to have moved. It also checks that a later, uninterrupted pass brings every register up to date.

// File: rtl/calib_shadow_pkg.sv
package calib_shadow_pkg;
  localparam int TAG_W = 4;
  localparam int NREG  = 5;

  // register slots, in output order
  localparam int SLOT_CFG    = 0;
  localparam int SLOT_OFS    = 1;
  localparam int SLOT_OFS_TC = 2;
  localparam int SLOT_FSO    = 3;
  localparam int SLOT_FSO_TC = 4;

  typedef enum logic [TAG_W-1:0] {
    TAG_CFG    = 4'b1000,
    TAG_OFS    = 4'b1001,
    TAG_OFS_TC = 4'b1010,
    TAG_FSO    = 4'b1011,
    TAG_FSO_TC = 4'b1100
  } tag_e;
endpackage

// File: rtl/refresh_seq.sv
module refresh_seq #(
  parameter int N_WORDS = 8,
  localparam int ADDR_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              run_en_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_WORDS - 1);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              vld_q, vld_d;

  always_comb begin
    busy_d = busy_q;
    addr_d = addr_q;
    vld_d  = busy_q & run_en_i;
    if (!run_en_i) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (addr_q == LAST) busy_d = 1'b0;
      else                addr_d = addr_q + 1'b1;
    end else if (tick_i) begin
      busy_d = 1'b1;
      addr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      addr_q <= addr_d;
      vld_q  <= vld_d;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/tag_decode.sv
module tag_decode
  import calib_shadow_pkg::*;
(
  input  logic [TAG_W-1:0] tag_i,
  output logic [NREG-1:0]  sel_o
);
  always_comb begin
    sel_o = '0;
    case (tag_i)
      TAG_CFG:    sel_o[SLOT_CFG]    = 1'b1;
      TAG_OFS:    sel_o[SLOT_OFS]    = 1'b1;
      TAG_OFS_TC: sel_o[SLOT_OFS_TC] = 1'b1;
      TAG_FSO:    sel_o[SLOT_FSO]    = 1'b1;
      TAG_FSO_TC: sel_o[SLOT_FSO_TC] = 1'b1;
      default:    sel_o = '0;
    endcase
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int NREG  = 5,
  parameter int PAY_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0]            we_i,
  input  logic [PAY_W-1:0]           data_i,
  output logic [NREG-1:0][PAY_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [PAY_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       val_q <= '0;
      else if (we_i[g]) val_q <= data_i;
    end
    assign regs_o[g] = val_q;
  end
endmodule

// File: rtl/calib_shadow_loader.sv
module calib_shadow_loader
  import calib_shadow_pkg::*;
#(
  parameter int PAY_W   = 12,
  parameter int N_WORDS = 8,
  localparam int WORD_W = TAG_W + PAY_W,
  localparam int ADDR_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              comm_active_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              prog_permit_o,
  output logic              busy_o,
  output logic [PAY_W-1:0]  cfg_o,
  output logic [PAY_W-1:0]  ofs_o,
  output logic [PAY_W-1:0]  ofs_tc_o,
  output logic [PAY_W-1:0]  fso_o,
  output logic [PAY_W-1:0]  fso_tc_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  logic rst_int_n;
  assign rst_int_n = rst_sync_q[1];

  logic run_en;
  assign run_en = wr_en_i & ~comm_active_i;

  logic word_vld;
  refresh_seq #(.N_WORDS(N_WORDS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (tick_i),
    .run_en_i (run_en),
    .busy_o   (busy_o),
    .addr_o   (mem_addr_o),
    .vld_o    (word_vld)
  );

  logic [NREG-1:0] tag_sel, reg_we;
  tag_decode u_dec (
    .tag_i (mem_data_i[WORD_W-1 -: TAG_W]),
    .sel_o (tag_sel)
  );
  assign reg_we = (word_vld & run_en) ? tag_sel : '0;

  logic [NREG-1:0][PAY_W-1:0] shadow_q;
  shadow_bank #(.NREG(NREG), .PAY_W(PAY_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_i   (reg_we),
    .data_i (mem_data_i[PAY_W-1:0]),
    .regs_o (shadow_q)
  );

  assign mem_rd_o      = busy_o;
  assign prog_permit_o = wr_en_i;
  assign cfg_o         = shadow_q[SLOT_CFG];
  assign ofs_o         = shadow_q[SLOT_OFS];
  assign ofs_tc_o      = shadow_q[SLOT_OFS_TC];
  assign fso_o         = shadow_q[SLOT_FSO];
  assign fso_tc_o      = shadow_q[SLOT_FSO_TC];
endmodule

// File: rtl/calib_shadow_chk.sv
module calib_shadow_chk
  import calib_shadow_pkg::*;
#(
  parameter int PAY_W  = 12,
  parameter int ADDR_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en_i,
  input logic                       comm_active_i,
  input logic                       busy_o,
  input logic [ADDR_W-1:0]          mem_addr_o,
  input logic [TAG_W+PAY_W-1:0]     mem_data_i,
  input logic                       word_vld,
  input logic [NREG-1:0][PAY_W-1:0] regs
);
  p_first_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> mem_addr_o == '0);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

  p_wr_low_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> !busy_o);

  p_comm_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    comm_active_i |=> !busy_o);

  p_zero_tag_inert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && mem_data_i[TAG_W+PAY_W-1 -: TAG_W] == '0) |=> $stable(regs));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(regs));

  p_offset_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && wr_en_i && !comm_active_i &&
     mem_data_i[TAG_W+PAY_W-1 -: TAG_W] == TAG_OFS)
    |=> regs[SLOT_OFS] == $past(mem_data_i[PAY_W-1:0]));
endmodule

bind calib_shadow_loader calib_shadow_chk #(.PAY_W(PAY_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en_i       (wr_en_i),
  .comm_active_i (comm_active_i),
  .busy_o        (busy_o),
  .mem_addr_o    (mem_addr_o),
  .mem_data_i    (mem_data_i),
  .word_vld      (word_vld),
  .regs          (shadow_q)
);

// File: tb/test_calib_shadow_loader.sv
module test_calib_shadow_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b1;
  logic        comm_active_i = 1'b0;
  logic        mem_rd_o, prog_permit_o, busy_o;
  logic [2:0]  mem_addr_o;
  logic [15:0] mem_data_i;
  logic [11:0] cfg_o, ofs_o, ofs_tc_o, fso_o, fso_tc_o;
  logic [15:0] mem [8];

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) if (mem_rd_o) mem_data_i <= mem[mem_addr_o];

  calib_shadow_loader i_calib_shadow_loader (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .comm_active_i(comm_active_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .prog_permit_o(prog_permit_o), .busy_o(busy_o),
    .cfg_o(cfg_o), .ofs_o(ofs_o), .ofs_tc_o(ofs_tc_o), .fso_o(fso_o),
    .fso_tc_o(fso_tc_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_regs(string req, logic [11:0] c, o, ot, f, ft);
    chk({req, " cfg"}, {4'h0, cfg_o}, {4'h0, c});
    chk({req, " ofs"}, {4'h0, ofs_o}, {4'h0, o});
    chk({req, " ofs_tc"}, {4'h0, ofs_tc_o}, {4'h0, ot});
    chk({req, " fso"}, {4'h0, fso_o}, {4'h0, f});
    chk({req, " fso_tc"}, {4'h0, fso_tc_o}, {4'h0, ft});
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic run_pass();
    pulse_tick();
    repeat (12) @(negedge clk);
  endtask

  task automatic load_std(logic [11:0] base);
    mem[0] = {4'b1000, base + 12'h001};
    mem[1] = {4'b1001, base + 12'h002};
    mem[2] = {4'b1010, base + 12'h003};
    mem[3] = {4'b1011, base + 12'h004};
    mem[4] = {4'b1100, base + 12'h005};
    mem[5] = {4'b0000, 12'hAAA};
    mem[6] = {4'b0000, 12'hBBB};
    mem[7] = {4'b0000, 12'hCCC};
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_regs("R1 in reset", 0, 0, 0, 0, 0);
    chk("R1 busy in reset", {15'd0, busy_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_regs("R1 after release", 0, 0, 0, 0, 0);
    chk("R1 rd after release", {15'd0, mem_rd_o}, 0);
  endtask

  task automatic t_map_and_order();
    load_std(12'h100);
    pulse_tick();
    for (int i = 0; i < 8; i++) begin
      chk("R5 busy during pass", {15'd0, busy_o}, 1);
      chk("R5 address order", {13'd0, mem_addr_o}, 16'(i));
      @(negedge clk);
    end
    chk("R5 busy after 8", {15'd0, busy_o}, 0);
    repeat (4) @(negedge clk);
    chk_regs("R2 map", 12'h101, 12'h102, 12'h103, 12'h104, 12'h105);
  endtask

  task automatic t_tag_not_address();
    mem[0] = {4'b1011, 12'h111};
    mem[1] = {4'b1001, 12'h222};
    mem[2] = {4'b0111, 12'h333};
    mem[3] = {4'b0000, 12'h444};
    mem[4] = {4'b1100, 12'h555};
    mem[5] = {4'b1000, 12'h666};
    mem[6] = {4'b1111, 12'h777};
    mem[7] = {4'b0000, 12'h888};
    run_pass();
    chk("R4 fso from addr0", {4'h0, fso_o}, 16'h0111);
    chk("R4 cfg from addr5", {4'h0, cfg_o}, 16'h0666);
    chk("R3 bad tag leaves ofs_tc", {4'h0, ofs_tc_o}, 16'h0103);
    chk("R2 ofs", {4'h0, ofs_o}, 16'h0222);
    chk("R2 fso_tc", {4'h0, fso_tc_o}, 16'h0555);
  endtask

  task automatic t_duplicate();
    load_std(12'h200);
    mem[1] = {4'b1001, 12'h0AA};
    mem[6] = {4'b1001, 12'h0BB};
    run_pass();
    chk("R9 later word wins", {4'h0, ofs_o}, 16'h00BB);
  endtask

  task automatic t_wr_low();
    load_std(12'h300);
    @(negedge clk) wr_en_i = 1'b0;
    @(negedge clk);
    chk("R6 permit low", {15'd0, prog_permit_o}, 0);
    pulse_tick();
    chk("R6 no busy", {15'd0, busy_o}, 0);
    repeat (12) @(negedge clk);
    chk_regs("R6 regs held", 12'h201, 12'h0BB, 12'h203, 12'h204, 12'h205);
    @(negedge clk) wr_en_i = 1'b1;
    @(negedge clk);
    chk("R6 permit high", {15'd0, prog_permit_o}, 1);
  endtask

  task automatic t_comm();
    comm_active_i = 1'b1;
    pulse_tick();
    chk("R7 no busy", {15'd0, busy_o}, 0);
    repeat (12) @(negedge clk);
    chk_regs("R7 regs held", 12'h201, 12'h0BB, 12'h203, 12'h204, 12'h205);
    comm_active_i = 1'b0;
  endtask

  task automatic t_abandon();
    load_std(12'h400);
    pulse_tick();
    while (mem_addr_o != 3'd2) @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
    chk("R8 busy drops", {15'd0, busy_o}, 0);
    repeat (6) @(negedge clk);
    chk_regs("R8 partial", 12'h401, 12'h0BB, 12'h203, 12'h204, 12'h205);
    wr_en_i = 1'b1;
    run_pass();
    chk_regs("R8 resumed", 12'h401, 12'h402, 12'h403, 12'h404, 12'h405);
  endtask

  task automatic t_tick_in_pass();
    int n_busy = 0;
    load_std(12'h500);
    pulse_tick();
    for (int i = 0; i < 14; i++) begin
      if (i == 3) tick_i = 1'b1;
      if (i == 4) tick_i = 1'b0;
      if (busy_o) n_busy++;
      @(negedge clk);
    end
    chk("R10 pass length", 16'(n_busy), 16'd8);
    chk_regs("R10 regs", 12'h501, 12'h502, 12'h503, 12'h504, 12'h505);
  endtask

  initial begin
    t_reset();
    t_map_and_order();
    t_tag_not_address();
    t_duplicate();
    t_wr_low();
    t_comm();
    t_abandon();
    t_tick_in_pass();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule